// File: doc/BRIEF.md
# CDR Proportional-Integral Phase Controller

This block is the digital loop filter of a clock and data recovery loop. Once per word clock it may receive a signed, already decimated phase-error value. It turns that value into the multi-bit code that steers a digital-to-phase converter. The phase detectors and the converter itself are outside this block.

The error feeds two paths. The proportional path scales the error by a fixed 2^-3 and sends it straight to the phase integrator. The integral path adds a smaller, selectable power-of-two fraction of the error into a signed frequency register. That register saturates at both ends, so it can hold a positive or a negative frequency offset without rolling over. On every accepted sample, the phase integrator adds the proportional term and the current frequency value. The phase integrator is unsigned and wraps freely, so the output phase can keep ramping across any number of unit intervals.

All arithmetic is fixed point with `FRAC_W` fractional bits below the code LSB. The phase code is the top `CODE_W` bits of the phase integrator. With the default of 512 codes per UI, the 12-bit code spans 8 UI before it wraps. The loop delay through the block is one register stage.

Top module: `cdr_pi_ctrl`

## Requirements
- R1: While `rst_ni` is low, and asynchronously when it falls, the phase integrator and the frequency register clear to zero, so `code_o` reads 0 and stays 0 under zero-error samples after release.
- R2: In a cycle with `valid_i` low, neither integrator changes, whatever `err_i` and `gsel_i` carry.
- R3: An accepted sample with error e adds e/8 code LSBs to the phase integrator, which is e*512 units at 12 fractional bits.
- R4: An accepted sample adds e*2^-k code LSBs to the frequency register. The shift k is taken from `gsel_i` of that same sample: 0 gives k=8, 1 gives k=10, and 2 or 3 give k=12.
- R5: An accepted sample also adds the frequency register value held before that sample's own update to the phase integrator.
- R6: The phase integrator is CODE_W+FRAC_W bits wide and wraps modulo 2^(CODE_W+FRAC_W). `code_o` is its top CODE_W bits.
- R7: The frequency register is FREQ_W bits, signed. It saturates at 2^(FREQ_W-1)-1 and at -2^(FREQ_W-1) and never changes sign by overflow.
- R8: `code_o` reflects a sample on the first rising clock edge after the sample is presented. There is no combinational path from the inputs to `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `err_i` and `gsel_i` as a sample to accept |
| err_i | input | ERR_W | Signed decimated phase error |
| gsel_i | input | 2 | Integral gain select (0: 2^-8, 1: 2^-10, 2/3: 2^-12) |
| code_o | output | CODE_W | Phase code for the phase converter |

## Verification
A corrupted frequency register shows up one accepted sample later as a wrong phase step under zero error. From then on, the fault accumulates in `code_o` on every sample. A sign wrap in the frequency register turns a steady upward ramp of about 32 codes per sample into a downward one in a single cycle, so saturation is checked by measuring the code step after long drives of maximum error in each direction. A wrong proportional shift or a wrong integral shift appears on the next edge as a code that differs from a hand-computed sequence.

// File: rtl/cdr_pi_pkg.sv
package cdr_pi_pkg;
  localparam int GSEL_W = 2;

  typedef enum logic [GSEL_W-1:0] {
    GSEL_FAST = 2'd0,
    GSEL_MID  = 2'd1,
    GSEL_SLOW = 2'd2,
    GSEL_ALT  = 2'd3
  } gsel_e;

  localparam int NUM_KI = 3;
endpackage

// File: rtl/cdr_gain_scale.sv
// Places a signed integer error into fixed point and scales it by 2^-SHIFT.
module cdr_gain_scale #(
  parameter int IN_W   = 5,
  parameter int FRAC_W = 12,
  parameter int SHIFT  = 3,
  localparam int OUT_W = IN_W + FRAC_W
) (
  input  logic signed [IN_W-1:0]  err_i,
  output logic signed [OUT_W-1:0] term_o
);
  localparam int SH = FRAC_W - SHIFT;

  logic signed [OUT_W-1:0] ext;

  assign ext    = {{(OUT_W-IN_W){err_i[IN_W-1]}}, err_i};
  assign term_o = ext <<< SH;
endmodule

// File: rtl/cdr_freq_integ.sv
// Signed, saturating frequency register.
module cdr_freq_integ #(
  parameter int STEP_W = 17,
  parameter int FREQ_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic signed [FREQ_W-1:0] freq_o
);
  localparam logic signed [FREQ_W-1:0] F_MAX = {1'b0, {(FREQ_W-1){1'b1}}};
  localparam logic signed [FREQ_W-1:0] F_MIN = {1'b1, {(FREQ_W-1){1'b0}}};

  logic signed [FREQ_W-1:0] freq_q, freq_d;
  logic signed [FREQ_W:0]   sum;

  assign sum = {freq_q[FREQ_W-1], freq_q}
             + {{(FREQ_W+1-STEP_W){step_i[STEP_W-1]}}, step_i};

  always_comb begin
    if (sum[FREQ_W] != sum[FREQ_W-1]) freq_d = sum[FREQ_W] ? F_MIN : F_MAX;
    else                              freq_d = sum[FREQ_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   freq_q <= '0;
    else if (en_i) freq_q <= freq_d;
  end

  assign freq_o = freq_q;
endmodule

// File: rtl/cdr_phase_integ.sv
// Unsigned, freely wrapping phase accumulator; exports its integer bits.
module cdr_phase_integ #(
  parameter int CODE_W = 12,
  parameter int FRAC_W = 12,
  parameter int PROP_W = 17,
  parameter int FREQ_W = 18,
  localparam int ACC_W = CODE_W + FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [PROP_W-1:0] prop_i,
  input  logic signed [FREQ_W-1:0] freq_i,
  output logic [CODE_W-1:0]        code_o
);
  logic [ACC_W-1:0] acc_q, prop_x, freq_x;

  assign prop_x = {{(ACC_W-PROP_W){prop_i[PROP_W-1]}}, prop_i};
  assign freq_x = {{(ACC_W-FREQ_W){freq_i[FREQ_W-1]}}, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_q + prop_x + freq_x;
  end

  assign code_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/cdr_pi_ctrl.sv
module cdr_pi_ctrl
  import cdr_pi_pkg::*;
#(
  parameter int ERR_W     = 5,
  parameter int CODE_W    = 12,
  parameter int FRAC_W    = 12,
  parameter int FREQ_W    = 18,
  parameter int KP_SHIFT  = 3,
  parameter int KI_SHIFT0 = 8,
  parameter int KI_SHIFT1 = 10,
  parameter int KI_SHIFT2 = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [GSEL_W-1:0]       gsel_i,
  output logic [CODE_W-1:0]       code_o
);
  localparam int STEP_W = ERR_W + FRAC_W;
  localparam int KI_SHIFT [NUM_KI] = '{KI_SHIFT0, KI_SHIFT1, KI_SHIFT2};

  logic signed [STEP_W-1:0] prop_w;
  logic signed [STEP_W-1:0] ki_w [NUM_KI];
  logic signed [STEP_W-1:0] ki_sel;
  logic signed [FREQ_W-1:0] freq_w;

  cdr_gain_scale #(.IN_W(ERR_W), .FRAC_W(FRAC_W), .SHIFT(KP_SHIFT)) u_kp (
    .err_i (err_i),
    .term_o(prop_w)
  );

  for (genvar g = 0; g < NUM_KI; g++) begin : g_ki
    cdr_gain_scale #(.IN_W(ERR_W), .FRAC_W(FRAC_W), .SHIFT(KI_SHIFT[g])) u_ki (
      .err_i (err_i),
      .term_o(ki_w[g])
    );
  end

  always_comb begin
    unique case (gsel_e'(gsel_i))
      GSEL_FAST: ki_sel = ki_w[0];
      GSEL_MID:  ki_sel = ki_w[1];
      default:   ki_sel = ki_w[2];
    endcase
  end

  cdr_freq_integ #(.STEP_W(STEP_W), .FREQ_W(FREQ_W)) u_freq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .step_i(ki_sel),
    .freq_o(freq_w)
  );

  // Phase adds the frequency value held before this sample's update.
  cdr_phase_integ #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .PROP_W(STEP_W), .FREQ_W(FREQ_W)
  ) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .prop_i(prop_w),
    .freq_i(freq_w),
    .code_o(code_o)
  );
endmodule

// File: rtl/cdr_pi_ctrl_chk.sv
module cdr_pi_ctrl_chk #(
  parameter int ERR_W  = 5,
  parameter int CODE_W = 12,
  parameter int FREQ_W = 18
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic signed [ERR_W-1:0] err_i,
  input logic [CODE_W-1:0]       code_o,
  input logic signed [FREQ_W-1:0] freq_i
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o) && $stable(freq_i));

  a_r7_no_pos_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !freq_i[FREQ_W-1] && !err_i[ERR_W-1] |=> !freq_i[FREQ_W-1]);

  a_r7_no_neg_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && freq_i[FREQ_W-1] && err_i[ERR_W-1] |=> freq_i[FREQ_W-1]);

  a_r4_zero_err_freq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && err_i == '0 |=> $stable(freq_i));

  a_r5_idle_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && err_i == '0 && freq_i == '0 |=> $stable(code_o));
endmodule

bind cdr_pi_ctrl cdr_pi_ctrl_chk #(
  .ERR_W(ERR_W), .CODE_W(CODE_W), .FREQ_W(FREQ_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .err_i  (err_i),
  .code_o (code_o),
  .freq_i (freq_w)
);

// File: tb/tb_cdr_pi_ctrl.sv
module tb_cdr_pi_ctrl;
  localparam int ERR_W = 5;
  localparam int CODE_W = 12;
  localparam int FRAC_W = 12;
  localparam int FREQ_W = 18;
  localparam longint ACC_MASK = (64'd1 << (CODE_W + FRAC_W)) - 1;
  localparam longint F_MAX = (64'sd1 <<< (FREQ_W - 1)) - 1;
  localparam longint F_MIN = -(64'sd1 <<< (FREQ_W - 1));
  localparam int NV = 10;

  // Stimulus (valid, error, gain select) and expected code after the edge.
  localparam int tv_v   [NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
  localparam int tv_e   [NV] = '{8, 8, 0, 8, -8, -8, -8, 0, -16, 4};
  localparam int tv_g   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 2, 1};
  localparam int tv_exp [NV] = '{1, 2, 2, 2, 1, 0, 4095, 4095, 4093, 4093};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic [1:0] gsel = 2'd0;
  logic [CODE_W-1:0] code;

  int checks = 0;
  int fails = 0;
  longint m_ph = 0;
  longint m_fr = 0;

  always #10 clk = ~clk;

  cdr_pi_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid),
    .err_i(err), .gsel_i(gsel), .code_o(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int kshift(input int g);
    return (g == 0) ? 8 : (g == 1) ? 10 : 12;
  endfunction

  // Drive at a falling edge, pass one rising edge, return at the next falling edge.
  task automatic drive(input int v, input int e, input int g);
    valid = (v != 0);
    err   = ERR_W'(e);
    gsel  = 2'(g);
    @(posedge clk);
    if (v != 0) begin
      m_ph = (m_ph + longint'(e) * 512 + m_fr) & ACC_MASK;
      m_fr = m_fr + (longint'(e) <<< (FRAC_W - kshift(g)));
      if (m_fr > F_MAX) m_fr = F_MAX;
      if (m_fr < F_MIN) m_fr = F_MIN;
    end
    @(negedge clk);
  endtask

  function automatic int mcode();
    return int'(m_ph >> FRAC_W);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    m_ph = 0;
    m_fr = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int prev, bad, wraps, d;
    repeat (3) @(negedge clk);
    chk("R1 code during reset", int'(code), 0);
    rst_ni = 1'b1;

    // Vector table: R3 proportional, R4 integral, R5 frequency into phase, R6 wrap, R2 hold
    for (int i = 0; i < NV; i++) begin
      drive(tv_v[i], tv_e[i], tv_g[i]);
      chk($sformatf("R3/R4/R5/R6 vector %0d", i), int'(code), tv_exp[i]);
    end

    // R2: valid low with large error and other gain leaves code unchanged over several edges
    prev = int'(code);
    for (int i = 0; i < 4; i++) drive(0, -16, 0);
    chk("R2 hold with valid low", int'(code), prev);
    drive(1, 0, 0);
    chk("R2 freq untouched by ignored samples", int'(code), mcode());

    // R1: asynchronous reset mid-run clears phase and frequency
    valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", int'(code), 0);
    m_ph = 0;
    m_fr = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) drive(1, 0, 0);
    chk("R1 frequency cleared", int'(code), 0);

    // R8: no combinational path; the change appears after the next rising edge
    valid = 1'b1;
    err = ERR_W'(15);
    gsel = 2'd0;
    #2;
    chk("R8 no change before edge", int'(code), 0);
    drive(1, 15, 0);
    chk("R8 change after one edge", int'(code), mcode());

    // R4: select 3 behaves as select 2
    do_reset();
    drive(1, 15, 3);
    for (int i = 0; i < 300; i++) drive(1, 0, 3);
    chk("R4 select 3 uses 2^-12", int'(code), mcode());
    do_reset();
    drive(1, 15, 2);
    for (int i = 0; i < 300; i++) drive(1, 0, 2);
    chk("R4 select 2 uses 2^-12", int'(code), mcode());
    drive(1, 7, 1);
    for (int i = 0; i < 20; i++) drive(1, 0, 1);
    chk("R4 select 1 uses 2^-10", int'(code), mcode());

    // R7 positive saturation, R6 wrap during the ramp
    do_reset();
    bad = 0;
    wraps = 0;
    prev = 0;
    for (int i = 0; i < 1500; i++) begin
      drive(1, 15, 0);
      if (int'(code) != mcode()) bad++;
      if (int'(code) < prev) wraps++;
      prev = int'(code);
    end
    chk("R7 model tracking on positive ramp", bad, 0);
    chk("R6 code wrapped during ramp", int'(wraps > 0), 1);
    for (int i = 0; i < 4; i++) begin
      prev = int'(code);
      drive(1, 0, 0);
      d = (int'(code) - prev + 4096) % 4096;
      chk("R7 step at positive limit within 31..32", int'(d >= 31 && d <= 32), 1);
    end

    // R7 negative saturation: step is exactly -32 codes
    bad = 0;
    for (int i = 0; i < 3000; i++) begin
      drive(1, -16, 0);
      if (int'(code) != mcode()) bad++;
    end
    chk("R7 model tracking on negative ramp", bad, 0);
    for (int i = 0; i < 4; i++) begin
      prev = int'(code);
      drive(1, 0, 0);
      d = (int'(code) - prev + 4096) % 4096;
      chk("R7 step at negative limit", d, 4064);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule